// File: doc/BRIEF.md
# Fractional-Rate Clock Enable Generator

This block turns a parent clock into a single-cycle clock-enable stream. The average rate of that stream is the parent rate scaled by mult/32 and then by a fixed integer post-divider. The rate comes from pulse swallowing: a 5-bit phase accumulator adds mult on every parent cycle, and each carry out of it passes one pulse on to the post-divider. No clock is generated or gated.

Software programs the rate through two registers.

- **Control register:** holds a 5-bit field at a parameterised bit offset. The field stores 32 minus mult, so a field of 0 runs at full rate and a field of 31 runs at 1/32.
- **Trigger register:** bit 31 is the trigger bit. Setting it asks the block to load the pending field into the running divider. The load happens on the next boundary of the free-running 32-cycle window.

The trigger bit clears itself a fixed number of cycles after the load. While it is still set, the block refuses a new field and a second trigger, and software reads the set bit as busy.

Top module: `frac_clk_gen`

## Requirements
- R1: After reset the control register reads 0, the trigger bit reads 0, and the output runs at full rate (mult = 32).
- R2: With running field value f (0..31), mult = 32 - f. Over any stretch of 32 × POST_DIV × K parent cycles in steady state, `clk_en` is high for exactly (32 - f) × K cycles.
- R3: Address 0 is the control register. Its field occupies bits FIELD_OFS to FIELD_OFS+4. Writes to its other bits are ignored and those bits read 0.
- R4: A write to address 1 with bit 31 set, while the trigger bit is clear, sets the trigger bit. Address 1 reads the trigger bit in bit 31 and zeros elsewhere.
- R5: The running field changes only at the edge that ends a 32-cycle window, counted from reset. Writing the control register without a trigger leaves the output rate unchanged.
- R6: Let n be the first edge after the trigger write that is a multiple of 32, counted in edges since reset release. The running field loads at edge n. The trigger bit clears at edge n + KICK_LAT. When it clears, the running field equals the pending field.
- R7: While the trigger bit is set, writes to the control register are ignored.
- R8: `clk_en` is a single-cycle pulse. When POST_DIV > 1, it is never high in two consecutive cycles.
- R9: Register reads have one cycle of latency. `reg_rdata` reflects the register selected by `reg_addr` at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 trigger |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| clk_en | output | 1 | Rate-scaled clock-enable pulse |

## Verification
The bench sweeps all 32 field values. For each value it triggers a load and counts enables over a whole number of 32 × POST_DIV windows. An exact count separates every mult from its neighbours and catches any off-by-one in the inversion or in the carry detection.

A write to the control register with no trigger shows whether the pending field leaks into the running divider. Issuing a trigger at a known edge and polling the trigger bit pins the window-aligned load and the fixed clear delay to exact edges. A control write issued while busy checks that updates are rejected, and an all-ones write checks the field position.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  localparam int FIELD_W  = 5;
  localparam int WIN      = 1 << FIELD_W;
  localparam int KICK_BIT = 31;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [FIELD_W:0]   mult_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_KICK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frac_regs.sv
module frac_regs
  import frac_clk_pkg::*;
#(
  parameter int FIELD_OFS = 8,
  parameter int KICK_LAT  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic        addr,
  input  logic [31:0] wdata,
  input  logic        win_last,
  output logic [31:0] rdata,
  output field_t      pend_field,
  output field_t      act_field,
  output logic        kick_busy
);
  localparam int SW = $clog2(KICK_LAT + 1);

  field_t          pend_q, act_q;
  logic            kick_q;
  logic [SW-1:0]   settle_q;
  logic [31:0]     rdata_q;
  logic            apply;
  logic            wr_ctrl, wr_kick;

  assign wr_ctrl = we && (addr == SEL_CTRL) && !kick_q;
  assign wr_kick = we && (addr == SEL_KICK) && wdata[KICK_BIT] && !kick_q;
  assign apply   = kick_q && win_last && (settle_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      act_q    <= '0;
      kick_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      if (wr_ctrl) pend_q <= wdata[FIELD_OFS +: FIELD_W];
      if (wr_kick) kick_q <= 1'b1;
      if (apply) begin
        act_q    <= pend_q;
        settle_q <= SW'(KICK_LAT);
      end else if (settle_q != '0) begin
        settle_q <= settle_q - 1'b1;
        if (settle_q == SW'(1)) kick_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (addr == SEL_KICK) rdata_q[KICK_BIT] <= kick_q;
      else                  rdata_q[FIELD_OFS +: FIELD_W] <= pend_q;
    end
  end

  assign rdata      = rdata_q;
  assign pend_field = pend_q;
  assign act_field  = act_q;
  assign kick_busy  = kick_q;
endmodule

// File: rtl/frac_rate_acc.sv
module frac_rate_acc
  import frac_clk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  field_t act_field,
  output logic   win_last,
  output logic   pulse
);
  field_t acc_q, win_q;
  logic   pulse_q;
  mult_t  mult;
  mult_t  sum;

  assign mult = mult_t'(WIN) - {1'b0, act_field};
  assign sum  = {1'b0, acc_q} + mult;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      win_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= sum[FIELD_W-1:0];
      pulse_q <= sum[FIELD_W];
      win_q   <= win_q + 1'b1;
    end
  end

  assign win_last = (win_q == field_t'(WIN - 1));
  assign pulse    = pulse_q;
endmodule

// File: rtl/frac_post_div.sv
module frac_post_div #(
  parameter int POST_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic en
);
  logic en_q;

  generate
    if (POST_DIV == 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= pulse;
      end
    end else begin : g_div
      localparam int CW = $clog2(POST_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end else begin
          en_q <= pulse && (cnt_q == CW'(POST_DIV - 1));
          if (pulse) begin
            if (cnt_q == CW'(POST_DIV - 1)) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign en = en_q;
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen
  import frac_clk_pkg::*;
#(
  parameter int FIELD_OFS = 8,
  parameter int POST_DIV  = 2,
  parameter int KICK_LAT  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        clk_en
);
  initial begin
    if (FIELD_OFS < 0 || FIELD_OFS + FIELD_W > KICK_BIT)
      $error("FIELD_OFS out of range");
    if (KICK_LAT < 1 || KICK_LAT >= WIN)
      $error("KICK_LAT out of range");
    if (POST_DIV < 1)
      $error("POST_DIV out of range");
  end

  field_t pend_field, act_field;
  logic   kick_busy, win_last, pulse;

  frac_regs #(.FIELD_OFS(FIELD_OFS), .KICK_LAT(KICK_LAT)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .win_last   (win_last),
    .rdata      (reg_rdata),
    .pend_field (pend_field),
    .act_field  (act_field),
    .kick_busy  (kick_busy)
  );

  frac_rate_acc u_acc (
    .clk       (clk),
    .rst       (rst),
    .act_field (act_field),
    .win_last  (win_last),
    .pulse     (pulse)
  );

  frac_post_div #(.POST_DIV(POST_DIV)) u_div (
    .clk   (clk),
    .rst   (rst),
    .pulse (pulse),
    .en    (clk_en)
  );
endmodule

// File: rtl/frac_clk_chk.sv
module frac_clk_chk
  import frac_clk_pkg::*;
#(
  parameter int POST_DIV = 2
) (
  input logic   clk,
  input logic   rst,
  input logic   reg_we,
  input logic   reg_addr,
  input logic   wd_kick,
  input logic   kick_busy,
  input field_t pend_field,
  input field_t act_field,
  input logic   win_last,
  input logic   clk_en
);
  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (kick_busy && reg_we && reg_addr == SEL_CTRL) |=> $stable(pend_field)); // R7

  AST_APPLY_ON_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_field) |-> $past(win_last)); // R5

  AST_CLEAR_MATCHES: assert property (@(posedge clk) disable iff (rst)
    $fell(kick_busy) |-> (act_field == pend_field)); // R6

  AST_KICK_SETS: assert property (@(posedge clk) disable iff (rst)
    (!kick_busy && reg_we && reg_addr == SEL_KICK && wd_kick) |=> kick_busy); // R4

  AST_EN_SPACED: assert property (@(posedge clk) disable iff (rst)
    ((POST_DIV > 1) && clk_en) |=> !clk_en); // R8
endmodule

bind frac_clk_gen frac_clk_chk #(.POST_DIV(POST_DIV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wd_kick    (reg_wdata[31]),
  .kick_busy  (kick_busy),
  .pend_field (pend_field),
  .act_field  (act_field),
  .win_last   (win_last),
  .clk_en     (clk_en)
);

// File: tb/frac_clk_gen_test.sv
`timescale 1ns/1ps
module frac_clk_gen_test;
  localparam int OFS  = 3;
  localparam int PDIV = 2;
  localparam int LAT  = 4;
  localparam int SPAN = 32 * PDIV * 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_en;

  int total = 0;
  int bad   = 0;
  int ecnt  = 0;
  int wdog  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  frac_clk_gen #(.FIELD_OFS(OFS), .POST_DIV(PDIV), .KICK_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FIAL-> %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic count_en(output int n);
    n = 0;
    for (int i = 0; i < SPAN; i++) begin
      @(negedge clk);
      if (clk_en) n++;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(1'b1, d);
      if (!d[31]) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      wdog++;
      if (wdog > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=150000", wdog);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    int w, nb, seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(1'b0, d); check("R1 ctrl", d, 0);
    rd(1'b1, d); check("R1 kick", d, 0);
    count_en(n); check("R1 full rate", n, 64);

    // R3 / R9: field position, other bits masked
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); check("R3 field mask", d, 32'h1F << OFS);
    wr(1'b0, 32'h0);
    rd(1'b0, d); check("R9 readback", d, 0);

    // R5: field write without trigger does not change rate
    wr(1'b0, 32'd16 << OFS);
    repeat (40) @(negedge clk);
    count_en(n); check("R5 no trigger", n, 64);

    // R4 / R6: exact trigger timing
    @(negedge clk);
    while ((ecnt % 32) != 10) @(negedge clk);
    w = ecnt + 1;
    wr(1'b1, 32'h8000_0000);
    reg_addr = 1'b1;
    @(negedge clk);
    check("R4 busy seen", reg_rdata[31], 1);
    seen = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!reg_rdata[31]) begin seen = ecnt; break; end
    end
    nb = ((w / 32) + 1) * 32;
    check("R6 clear edge", seen, nb + LAT + 1);
    repeat (8) @(negedge clk);
    count_en(n); check("R6 new rate", n, (32 - 16) * 2);

    // R7: control write rejected while busy
    wr(1'b0, 32'd4 << OFS);
    wr(1'b1, 32'h8000_0000);
    wr(1'b0, 32'd20 << OFS);
    wait_idle();
    rd(1'b0, d); check("R7 rejected write", d, 32'd4 << OFS);
    count_en(n); check("R7 rate", n, (32 - 4) * 2);

    // R2: sweep all field values
    for (int f = 0; f < 32; f++) begin
      wr(1'b0, 32'(f) << OFS);
      wr(1'b1, 32'h8000_0000);
      wait_idle();
      count_en(n);
      check($sformatf("R2 field=%0d", f), n, (32 - f) * 2);
    end

    done = 1'b1;
    finish_run();
  end
endmodule